// File: doc/BRIEF.md
# Drive Head Position and Media-Change Tracker

This block keeps, for each attached drive, the cylinder the head currently sits on and a media-change flag. A command sequencer elsewhere in the controller hands it seek requests. A request is either an absolute seek to a given cylinder, a relative move toward the spindle (inward, cylinder number grows) or a relative move toward the edge (outward, cylinder number shrinks). The block issues one step pulse per cylinder travelled, spaced by a programmable interval, and leaves an interrupt pending once the head arrives. A sense request then returns the completion status and the cylinder reached.

The media-change flag is readable at any time through the `dir_drive` select and the `disk_changed` output. It is forced on while a drive has no medium. It is cleared only by a real step of the head on that drive while a medium is inserted. Looking at it, inserting a medium, or a seek that does not move the head leaves it untouched.

The control sequence has three states. IDLE accepts a request (IDLE to MOVE on `req_valid`). MOVE steps the selected drive toward its target whenever the step interval allows, and leaves for DONE once the head position equals the target. DONE marks the drive's completion pending and returns to IDLE.

Top module: `dc_track_top`

## Requirements
- R1: After reset every drive is at cylinder 0 with its change flag set, nothing is pending, `busy` and `irq` are low.
- R2: An absolute seek (`req_kind`=0) moves to `min(req_arg, MAX_CYL)`. It issues exactly one `step_pulse` per cylinder of distance, with `step_inward` high when the cylinder number grows.
- R3: A relative inward seek (`req_kind`=1) adds `req_arg` to the cylinder and saturates at `MAX_CYL`. A relative outward seek (`req_kind`=2) subtracts it and saturates at 0.
- R4: Successive step pulses are never closer than `STEP_CYC` cycles; within one seek they come exactly `STEP_CYC` cycles apart.
- R5: Completion of a seek sets that drive's pending bit and raises `irq`. A sense request returns status 0x20 with the drive number in bits [1:0] and the drive's cylinder on `sense_cyl`, then clears that pending bit.
- R6: A sense request with nothing pending returns status 0x80 and cylinder 0.
- R7: When several drives are pending, sense requests report them in ascending drive-number order.
- R8: While a drive has no medium its change flag is set, including after an eject, and steps on that drive leave it set.
- R9: Selecting or observing the flag never clears it, and a seek to the cylinder already held issues no step and leaves the flag set.
- R10: Inserting a medium does not clear the flag. The first step on that drive with a medium present clears it, and flags of other drives are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Seek request strobe, taken in IDLE |
| req_kind | input | 2 | 0 absolute, 1 relative inward, 2 relative outward |
| req_drive | input | DRV_W | Drive addressed by the request |
| req_arg | input | CYL_W | Target cylinder or relative count |
| busy | output | 1 | High while a seek is in progress |
| step_pulse | output | 1 | One-cycle head step |
| step_inward | output | 1 | Step direction, high for growing cylinder |
| step_drive | output | DRV_W | Drive being stepped |
| media_present | input | NUM_DRIVES | Medium inserted, per drive |
| dir_drive | input | DRV_W | Drive whose change flag is shown |
| disk_changed | output | 1 | Change flag of the selected drive |
| sense_req | input | 1 | Sense-interrupt request |
| sense_valid | output | 1 | Sense result valid, one cycle after request |
| sense_status | output | 8 | Sense status byte |
| sense_cyl | output | CYL_W | Cylinder reported by sense |
| irq | output | 1 | Any drive pending |

## Verification
Absolute seeks are swept from every start cylinder of a small configuration to every target, including targets past the maximum. The step count, direction and spacing separate correct distance arithmetic from off-by-one and clamping faults. Relative moves are swept in both directions with counts that overrun both ends, which exposes wrong saturation. Flag sequences cover seeks without a medium, insertion, zero-distance seeks, real steps and eject, and tell clearing on step apart from clearing on insert, read or no-move. Back-to-back completions on two drives check the order in which sense reports them.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        SEEK_ABS = 2'd0,
        SEEK_IN  = 2'd1,
        SEEK_OUT = 2'd2
    } seek_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DONE = 2'd2
    } trk_state_e;

    localparam logic [7:0] SENSE_SEEK_END = 8'h20;
    localparam logic [7:0] SENSE_NONE     = 8'h80;
endpackage

// File: rtl/dc_target_calc.sv
module dc_target_calc #(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  logic [1:0]       kind,
    input  logic [CYL_W-1:0] cur,
    input  logic [CYL_W-1:0] arg,
    output logic [CYL_W-1:0] tgt
);
    import dc_pkg::*;
    localparam logic [CYL_W-1:0] MAX_C = CYL_W'(MAX_CYL);

    logic [CYL_W:0] sum;
    assign sum = {1'b0, cur} + {1'b0, arg};

    always_comb begin
        case (kind)
            SEEK_ABS: tgt = (arg > MAX_C) ? MAX_C : arg;
            SEEK_IN:  tgt = (sum > {1'b0, MAX_C}) ? MAX_C : sum[CYL_W-1:0];
            SEEK_OUT: tgt = (arg > cur) ? '0 : cur - arg;
            default:  tgt = cur;
        endcase
    end
endmodule

// File: rtl/dc_step_timer.sv
module dc_step_timer #(
    parameter int STEP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ready
);
    localparam int TW = $clog2(STEP_CYC + 1);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (fire)         cnt_q <= TW'(STEP_CYC - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/dc_sense_pick.sv
module dc_sense_pick #(
    parameter int NUM_DRIVES = 4,
    parameter int DRV_W      = 2
) (
    input  logic [NUM_DRIVES-1:0] pend,
    output logic                  any,
    output logic [DRV_W-1:0]      idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = DRV_W'(i);
            end
        end
    end
endmodule

// File: rtl/dc_track_top.sv
module dc_track_top #(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    parameter int MAX_CYL    = 79,
    parameter int STEP_CYC   = 8,
    localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [DRV_W-1:0]      req_drive,
    input  logic [CYL_W-1:0]      req_arg,
    output logic                  busy,
    output logic                  step_pulse,
    output logic                  step_inward,
    output logic [DRV_W-1:0]      step_drive,
    input  logic [NUM_DRIVES-1:0] media_present,
    input  logic [DRV_W-1:0]      dir_drive,
    output logic                  disk_changed,
    input  logic                  sense_req,
    output logic                  sense_valid,
    output logic [7:0]            sense_status,
    output logic [CYL_W-1:0]      sense_cyl,
    output logic                  irq
);
    import dc_pkg::*;
    localparam int GW = $clog2(STEP_CYC + 1);

    trk_state_e              state_q, state_d;
    logic [DRV_W-1:0]        drv_q;
    logic [CYL_W-1:0]        tgt_q, tgt_new, cur;
    logic [CYL_W-1:0]        pcn_q [NUM_DRIVES];
    logic [NUM_DRIVES-1:0]   chg_q, pend_q;
    logic                    tmr_ready, step_fire, pick_any, accept;
    logic [DRV_W-1:0]        pick_idx;

    assign cur       = pcn_q[drv_q];
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign step_fire = (state_q == ST_MOVE) && (cur != tgt_q) && tmr_ready;

    dc_target_calc #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_calc (
        .kind(req_kind), .cur(pcn_q[req_drive]), .arg(req_arg), .tgt(tgt_new)
    );

    dc_step_timer #(.STEP_CYC(STEP_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .fire(step_fire), .ready(tmr_ready)
    );

    dc_sense_pick #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_pick (
        .pend(pend_q), .any(pick_any), .idx(pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_MOVE;
            ST_MOVE: if (cur == tgt_q) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
            tgt_q <= '0;
        end else if (accept) begin
            drv_q <= req_drive;
            tgt_q <= tgt_new;
        end
    end

    // per-drive position, change flag and pending bit
    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
        logic here;
        assign here = (drv_q == DRV_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pcn_q[i]  <= '0;
                chg_q[i]  <= 1'b1;
                pend_q[i] <= 1'b0;
            end else begin
                if (step_fire && here)
                    pcn_q[i] <= (tgt_q > pcn_q[i]) ? pcn_q[i] + 1'b1 : pcn_q[i] - 1'b1;
                if (!media_present[i])
                    chg_q[i] <= 1'b1;
                else if (step_fire && here)
                    chg_q[i] <= 1'b0;
                if (state_q == ST_DONE && here)
                    pend_q[i] <= 1'b1;
                else if (sense_req && pick_any && pick_idx == DRV_W'(i))
                    pend_q[i] <= 1'b0;
            end
        end

        // R10
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(chg_q[i]) |-> $past(step_fire && here && media_present[i]));
        // R8
        eject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(media_present[i]) |=> chg_q[i]);
        // R3
        pcn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pcn_q[i] <= CYL_W'(MAX_CYL));
    end

    // sense response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_valid  <= 1'b0;
            sense_status <= '0;
            sense_cyl    <= '0;
        end else begin
            sense_valid <= sense_req;
            if (sense_req) begin
                if (pick_any) begin
                    sense_status <= SENSE_SEEK_END | 8'(pick_idx);
                    sense_cyl    <= pcn_q[pick_idx];
                end else begin
                    sense_status <= SENSE_NONE;
                    sense_cyl    <= '0;
                end
            end
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign step_pulse   = step_fire;
    assign step_inward  = (tgt_q > cur);
    assign step_drive   = drv_q;
    assign disk_changed = chg_q[dir_drive];
    assign irq          = |pend_q;

    // spacing monitor for the step interval
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       gap_q <= GW'(STEP_CYC);
        else if (step_fire)               gap_q <= GW'(1);
        else if (gap_q < GW'(STEP_CYC))   gap_q <= gap_q + 1'b1;
    end

    // R4
    step_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> gap_q >= GW'(STEP_CYC));
    // R6
    sense_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_req && pend_q == '0) |=> (sense_valid && sense_status == SENSE_NONE));
    // R5
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !sense_req) |=> irq);
endmodule

// File: tb/sim_dc_track_top.sv
module sim_dc_track_top;
    localparam int ND = 2, CW = 8, MX = 9, SC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, sense_req = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic req_drive = 1'b0, dir_drive = 1'b0;
    logic [CW-1:0] req_arg = '0;
    logic [ND-1:0] media_present = '0;
    logic busy, step_pulse, step_inward, step_drive, disk_changed;
    logic sense_valid, irq;
    logic [7:0] sense_status;
    logic [CW-1:0] sense_cyl;

    int checks = 0, errors = 0;
    int steps, ins_steps, cyc = 0, last_step = -1;
    logic [7:0] s_st;
    logic [CW-1:0] s_cyl;

    always #10 clk = ~clk;

    dc_track_top #(.NUM_DRIVES(ND), .CYL_W(CW), .MAX_CYL(MX), .STEP_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_drive(req_drive), .req_arg(req_arg), .busy(busy),
        .step_pulse(step_pulse), .step_inward(step_inward), .step_drive(step_drive),
        .media_present(media_present), .dir_drive(dir_drive),
        .disk_changed(disk_changed), .sense_req(sense_req),
        .sense_valid(sense_valid), .sense_status(sense_status),
        .sense_cyl(sense_cyl), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // step monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (step_pulse) begin
            steps++;
            if (step_inward) ins_steps++;
            // R4: spacing inside one seek
            if (last_step >= 0) check(cyc - last_step == SC, "R4 step spacing", cyc - last_step, SC);
            last_step = cyc;
        end
    end

    task automatic do_seek(input logic drv, input logic [1:0] kind, input int arg);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_drive = drv; req_arg = CW'(arg);
        steps = 0; ins_steps = 0; last_step = -1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_sense();
        @(negedge clk);
        sense_req = 1'b1;
        @(negedge clk);
        sense_req = 1'b0;
        check(sense_valid, "R5 sense valid", sense_valid, 1);
        s_st = sense_status; s_cyl = sense_cyl;
    endtask

    task automatic flag_of(input logic drv, output logic f);
        dir_drive = drv;
        #1 f = disk_changed;
    endtask

    initial begin
        logic f;
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !irq, "R1 busy/irq after reset", {busy, irq}, 0);
        flag_of(0, f); check(f, "R1 flag drive0", f, 1);
        flag_of(1, f); check(f, "R1 flag drive1", f, 1);
        // R6
        do_sense();
        check(s_st == 8'h80 && s_cyl == 0, "R6 empty sense", s_st, 8'h80);
        do_seek(0, 2'd2, 3);
        do_sense();
        check(s_cyl == 0, "R1 start cylinder 0", s_cyl, 0);

        // R8: no medium, steps leave flag set
        do_seek(0, 2'd0, 5);
        check(irq, "R5 irq after completion", irq, 1);
        flag_of(0, f); check(f, "R8 flag after step without medium", f, 1);
        do_sense();
        check(s_st == 8'h20 && s_cyl == 5, "R5 sense drive0", s_cyl, 5);
        check(!irq, "R5 irq cleared", irq, 0);

        // R10: insertion alone does not clear
        media_present[0] = 1'b1;
        repeat (3) @(negedge clk);
        flag_of(0, f); check(f, "R10 flag after insert", f, 1);
        // R9: zero-distance seek and repeated reads
        do_seek(0, 2'd0, 5);
        check(steps == 0, "R9 zero seek steps", steps, 0);
        flag_of(0, f); check(f, "R9 flag after zero seek", f, 1);
        flag_of(1, f); flag_of(0, f); flag_of(0, f);
        check(f, "R9 flag after repeated reads", f, 1);
        do_sense();
        // R10: real step clears
        do_seek(0, 2'd0, 6);
        flag_of(0, f); check(!f, "R10 flag after step with medium", f, 0);
        flag_of(1, f); check(f, "R10 other drive flag kept", f, 1);
        do_sense();

        // R2: absolute sweep on drive 1 (no medium)
        for (int s = 0; s <= MX; s++) begin
            for (int t = 0; t <= MX + 3; t++) begin
                do_seek(1, 2'd0, s);
                do_sense();
                do_seek(1, 2'd0, t);
                e = (t > MX) ? MX : t;
                check(steps == ((e > s) ? e - s : s - e), "R2 step count", steps, (e > s) ? e - s : s - e);
                check(ins_steps == ((e > s) ? e - s : 0), "R2 step direction", ins_steps, (e > s) ? e - s : 0);
                do_sense();
                check(s_st == 8'h21 && s_cyl == CW'(e), "R2 absolute target", s_cyl, e);
            end
        end
        flag_of(1, f); check(f, "R8 flag kept over sweep", f, 1);

        // R3: relative sweep on drive 0
        for (int s = 0; s <= MX; s++) begin
            for (int c = 0; c <= MX + 3; c++) begin
                do_seek(0, 2'd0, s); do_sense();
                do_seek(0, 2'd1, c); do_sense();
                e = (s + c > MX) ? MX : s + c;
                check(s_cyl == CW'(e), "R3 inward", s_cyl, e);
                do_seek(0, 2'd0, s); do_sense();
                do_seek(0, 2'd2, c); do_sense();
                e = (c > s) ? 0 : s - c;
                check(s_cyl == CW'(e), "R3 outward", s_cyl, e);
            end
        end

        // R7: ordering of two pending drives
        do_seek(1, 2'd0, 3);
        do_seek(0, 2'd0, 2);
        do_sense();
        check(s_st == 8'h20 && s_cyl == 2, "R7 first drive0", s_st, 8'h20);
        do_sense();
        check(s_st == 8'h21 && s_cyl == 3, "R7 then drive1", s_st, 8'h21);
        do_sense();
        check(s_st == 8'h80, "R6 none left", s_st, 8'h80);

        // R8: eject sets, later steps leave it set
        media_present[0] = 1'b0;
        @(negedge clk);
        flag_of(0, f); check(f, "R8 flag after eject", f, 1);
        do_seek(0, 2'd0, 7); do_sense();
        flag_of(0, f); check(f, "R8 flag after step post eject", f, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule